// File: doc/BRIEF.md
# Transmit 8b/10b Line Encoder with Idle Disparity Repair

The block turns a stream of bytes, each tagged as data or control, into 10-bit DC-balanced code-groups. It handles one lane (10-bit output) or two lanes (20-bit output) per beat, chosen by the `LANES` parameter. It keeps a running disparity across beats, and each lane can be told to use a supplied disparity instead of the tracked one. Idle ordered sets, formed by a comma K28.5 followed by a data group, have their data half rewritten so that the line always leaves the set at negative disparity. This lets the next packet start from a known state.

A bypass input passes raw bytes around the encoder. A mirror input reverses the whole output word, and it works in both modes. Input and output are valid/ready streams with one register stage between them. A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output word is held and nothing new is accepted.

Top module: `linecode_tx`

## Requirements
- R1: While `rst` is high, every lane of `out_code` shows the negative-disparity K28.5 group 10'h0FA and `out_valid` is low. The first encoded beat after release starts from negative disparity.
- R2: Each 10-bit lane slot holds the group with bit a at bit 9 and bit j at bit 0 (abcdei then fghj), following the standard 5b/6b and 3b/4b tables. Every encoded group has 4, 5 or 6 ones. A group produced at negative disparity has 5 or 6 ones, and one produced at positive disparity has 4 or 5.
- R3: Lane 0 (`in_data[7:0]`, `out_code[9:0]`) is encoded first. Each higher lane starts from the disparity left by the lane below it. The disparity kept for the next beat is the one left by the top lane.
- R4: With `in_k` set, bytes 0x1C+32·y (K28.y), 0xF7, 0xFB, 0xFD and 0xFE are encoded as control groups. Any other byte with `in_k` set is encoded as the data byte of the same value, with no error indication.
- R5: An idle set is a lane holding K28.5 (`in_k`=1, byte 0xBC) followed by a data lane (`in_k`=0) whose byte is neither 0xB5 (D21.5) nor 0x42 (D2.2). With two lanes the pair must sit in lanes 0 and 1 of one beat. With one lane the pair is two consecutive encoded beats. Only the data lane of a detected set is rewritten.
- R6: The rewritten byte is 0xC5 (D5.6) when the disparity entering that lane is negative, and 0x50 (D16.2) when it is positive. In both cases the disparity after the lane is negative.
- R7: When `in_force[i]` is 1, lane i is encoded from `in_dispval[i]` (1 = positive) instead of the tracked disparity. Later lanes and the stored disparity follow on from that forced start.
- R8: With `bypass` high, each lane slot carries {2'b00, byte} with no encoding and no idle rewrite. The stored disparity and the one-lane idle history are left unchanged.
- R9: With `rev_en` high, the whole `LANES*10`-bit word is mirrored (bit 0 with the top bit, bit 1 with the next, and so on), in both encoded and bypass modes.
- R10: An accepted beat appears on `out_code` one clock later with `out_valid` high. `in_ready` equals `!out_valid || out_ready`. While stalled the output word stays unchanged. `out_valid` drops once the word is taken and no new beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| bypass | input | 1 | Pass raw bytes without encoding |
| rev_en | input | 1 | Mirror the whole output word |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be taken |
| in_data | input | LANES*8 | Bytes, lane 0 in the low byte |
| in_k | input | LANES | Control flag per lane |
| in_force | input | LANES | Use supplied disparity for the lane |
| in_dispval | input | LANES | Supplied disparity, 1 = positive |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_code | output | LANES*10 | Code-groups, lane 0 in the low slot |

## Verification
The bench looks for idle sets that enter at each disparity. A design that picks the wrong rewrite leaves the line positive after the set, or emits a doubled disparity step. It sends D21.5 and D2.2 after a comma, because a matcher that is too loose would rewrite them. It forces each lane's disparity so that the chaining into the upper lane shows; a design that reused the tracked value would produce the opposite group. It places a bypass beat between positive-disparity beats, so a design that let bypass disturb the disparity state would shift every group after it. Finally, it stalls the output to catch words that change or are lost under back-pressure.

// File: rtl/linecode_pkg.sv
package linecode_pkg;

  localparam logic [9:0] K285_NEG   = 10'h0FA;
  localparam logic [7:0] BYTE_COMMA = 8'hBC;
  localparam logic [7:0] BYTE_D21_5 = 8'hB5;
  localparam logic [7:0] BYTE_D2_2  = 8'h42;
  localparam logic [7:0] BYTE_FLIP  = 8'hC5;  // D5.6: neutral, keeps negative
  localparam logic [7:0] BYTE_KEEP  = 8'h50;  // D16.2: flips positive to negative

  // abcdei for data value x, negative-disparity column
  function automatic logic [5:0] six_neg(input logic [4:0] x);
    logic [5:0] r;
    case (x)
      5'd0:  r = 6'b100111;  5'd1:  r = 6'b011101;
      5'd2:  r = 6'b101101;  5'd3:  r = 6'b110001;
      5'd4:  r = 6'b110101;  5'd5:  r = 6'b101001;
      5'd6:  r = 6'b011001;  5'd7:  r = 6'b111000;
      5'd8:  r = 6'b111001;  5'd9:  r = 6'b100101;
      5'd10: r = 6'b010101;  5'd11: r = 6'b110100;
      5'd12: r = 6'b001101;  5'd13: r = 6'b101100;
      5'd14: r = 6'b011100;  5'd15: r = 6'b010111;
      5'd16: r = 6'b011011;  5'd17: r = 6'b100011;
      5'd18: r = 6'b010011;  5'd19: r = 6'b110010;
      5'd20: r = 6'b001011;  5'd21: r = 6'b101010;
      5'd22: r = 6'b011010;  5'd23: r = 6'b111010;
      5'd24: r = 6'b110011;  5'd25: r = 6'b100110;
      5'd26: r = 6'b010110;  5'd27: r = 6'b110110;
      5'd28: r = 6'b001110;  5'd29: r = 6'b101110;
      5'd30: r = 6'b011110;  default: r = 6'b101011;
    endcase
    return r;
  endfunction

  // fghj for value y when the disparity after 6b is negative
  function automatic logic [3:0] four_neg(input logic [2:0] y, input logic alt);
    logic [3:0] r;
    case (y)
      3'd0: r = 4'b1011;
      3'd1: r = 4'b1001;
      3'd2: r = 4'b0101;
      3'd3: r = 4'b1100;
      3'd4: r = 4'b1101;
      3'd5: r = 4'b1010;
      3'd6: r = 4'b0110;
      default: r = alt ? 4'b0111 : 4'b1110;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sym_enc_lane.sv
module sym_enc_lane
  import linecode_pkg::*;
(
  input  logic [7:0] byte_in,
  input  logic       k_in,
  input  logic       rd_in,
  output logic [9:0] code,
  output logic       rd_out
);
  logic [4:0] x;
  logic [2:0] y;
  logic       ctl28, ctl_x7, alt;
  logic [5:0] six_base, six;
  logic [3:0] four_base, four;
  logic       bal6, bal4, rd_mid, comp6, comp4;

  assign x = byte_in[4:0];
  assign y = byte_in[7:5];

  always_comb begin
    ctl28  = k_in && (x == 5'd28);
    ctl_x7 = k_in && (y == 3'd7) &&
             (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30);

    six_base = ctl28 ? 6'b001111 : six_neg(x);
    bal6     = ($countones(six_base) == 3);
    comp6    = rd_in && (!bal6 || (x == 5'd7 && !ctl28));
    six      = comp6 ? ~six_base : six_base;
    rd_mid   = rd_in ^ !bal6;

    alt = (y == 3'd7) &&
          (ctl28 || ctl_x7 ||
           (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
           (rd_mid  && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    four_base = four_neg(y, alt);
    bal4      = ($countones(four_base) == 2);
    // balanced comma tails run the other way round
    comp4 = ((!bal4 || y == 3'd3) && rd_mid) ||
            (ctl28 && bal4 && y != 3'd3 && !rd_mid);
    four  = comp4 ? ~four_base : four_base;

    code   = {six, four};
    rd_out = rd_mid ^ !bal4;
  end
endmodule

// File: rtl/idle_rewrite.sv
module idle_rewrite
  import linecode_pkg::*;
(
  input  logic       prev_comma,
  input  logic [7:0] byte_in,
  input  logic       k_in,
  input  logic       rd_sel,
  output logic [7:0] byte_out,
  output logic       hit
);
  always_comb begin
    hit = prev_comma && !k_in &&
          (byte_in != BYTE_D21_5) && (byte_in != BYTE_D2_2);
    if (hit) byte_out = rd_sel ? BYTE_KEEP : BYTE_FLIP;
    else     byte_out = byte_in;
  end
endmodule

// File: rtl/word_mirror.sv
module word_mirror #(
  parameter int W = 20
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] flipped;

  for (genvar j = 0; j < W; j++) begin : g_bit
    assign flipped[j] = din[W-1-j];
  end

  assign dout = en ? flipped : din;
endmodule

// File: rtl/linecode_tx.sv
module linecode_tx
  import linecode_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bypass,
  input  logic                rev_en,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*8-1:0]  in_data,
  input  logic [LANES-1:0]    in_k,
  input  logic [LANES-1:0]    in_force,
  input  logic [LANES-1:0]    in_dispval,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES*10-1:0] out_code
);
  localparam int CW = LANES * 10;

  logic             rd_q, byp_q, accept;
  logic [LANES:0]   rd_chain;
  logic [LANES-1:0] prev_comma, lane_hit;
  logic [CW-1:0]    enc_word, raw_word, pre_word, post_word;

  assign in_ready    = !out_valid || out_ready;
  assign accept      = in_valid && in_ready;
  assign rd_chain[0] = rd_q;

  if (LANES == 1) begin : g_hist
    logic hist_q;
    always_ff @(posedge clk or posedge rst) begin
      if (rst)                     hist_q <= 1'b0;
      else if (accept && !bypass)  hist_q <= in_k[0] && (in_data[7:0] == BYTE_COMMA);
    end
    assign prev_comma[0] = hist_q;
  end else begin : g_nohist
    assign prev_comma[0] = 1'b0;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] b, fixed_b;
    logic       rd_sel, fixed_k;

    assign b      = in_data[i*8 +: 8];
    assign rd_sel = in_force[i] ? in_dispval[i] : rd_chain[i];

    if (i > 0) begin : g_pair
      assign prev_comma[i] = in_k[i-1] && (in_data[(i-1)*8 +: 8] == BYTE_COMMA);
    end

    idle_rewrite u_idle (
      .prev_comma (prev_comma[i]),
      .byte_in    (b),
      .k_in       (in_k[i]),
      .rd_sel     (rd_sel),
      .byte_out   (fixed_b),
      .hit        (lane_hit[i])
    );
    assign fixed_k = in_k[i] && !lane_hit[i];

    sym_enc_lane u_enc (
      .byte_in (fixed_b),
      .k_in    (fixed_k),
      .rd_in   (rd_sel),
      .code    (enc_word[i*10 +: 10]),
      .rd_out  (rd_chain[i+1])
    );

    assign raw_word[i*10 +: 10] = {2'b00, b};
  end

  assign pre_word = bypass ? raw_word : enc_word;

  word_mirror #(.W(CW)) u_mirror (
    .en   (rev_en),
    .din  (pre_word),
    .dout (post_word)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      out_code  <= {LANES{K285_NEG}};
      out_valid <= 1'b0;
      rd_q      <= 1'b0;
      byp_q     <= 1'b0;
    end else begin
      if (accept) begin
        out_code <= post_word;
        byp_q    <= bypass;
        if (!bypass) rd_q <= rd_chain[LANES];
      end
      out_valid <= accept || (out_valid && !out_ready);
    end
  end

  AST_RST_COMMA: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (out_code == {LANES{K285_NEG}}) && !out_valid); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_code)); // R10

  AST_BYPASS_RD: assert property (@(posedge clk) disable iff (rst)
    accept && bypass |=> $stable(rd_q)); // R8

  AST_IDLE_NEG: assert property (@(posedge clk) disable iff (rst)
    accept && !bypass && lane_hit[LANES-1] |=> !rd_q); // R6

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    AST_SYM_WEIGHT: assert property (@(posedge clk) disable iff (rst)
      out_valid && !byp_q |->
        ($countones(out_code[i*10 +: 10]) >= 4) &&
        ($countones(out_code[i*10 +: 10]) <= 6)); // R2
  end
endmodule

// File: tb/linecode_tx_test.sv
module linecode_tx_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byp, rev, iv, ordy, irdy, ov;
  logic [15:0] din;
  logic [1:0]  kk, frc, dv;
  logic [19:0] code;

  logic       iv1, irdy1, ov1;
  logic [7:0] din1;
  logic       k1;
  logic [9:0] code1;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  linecode_tx #(.LANES(2)) uut (
    .clk(clk), .rst(rst), .bypass(byp), .rev_en(rev),
    .in_valid(iv), .in_ready(irdy), .in_data(din), .in_k(kk),
    .in_force(frc), .in_dispval(dv),
    .out_valid(ov), .out_ready(ordy), .out_code(code)
  );

  linecode_tx #(.LANES(1)) uut1 (
    .clk(clk), .rst(rst), .bypass(1'b0), .rev_en(1'b0),
    .in_valid(iv1), .in_ready(irdy1), .in_data(din1), .in_k(k1),
    .in_force(1'b0), .in_dispval(1'b0),
    .out_valid(ov1), .out_ready(1'b1), .out_code(code1)
  );

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] mirror20(input logic [19:0] w);
    logic [19:0] r;
    for (int j = 0; j < 20; j++) r[j] = w[19-j];
    return r;
  endfunction

  task automatic send2(input logic [7:0] hi, input logic [7:0] lo, input logic [1:0] k,
                       input logic [1:0] f, input logic [1:0] v, input logic b, input logic r);
    din = {hi, lo}; kk = k; frc = f; dv = v; byp = b; rev = r; iv = 1'b1;
    @(posedge clk); #1;
    iv = 1'b0;
  endtask

  task automatic send1(input logic [7:0] d, input logic k);
    din1 = d; k1 = k; iv1 = 1'b1;
    @(posedge clk); #1;
    iv1 = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset code", code, {10'h0FA, 10'h0FA});
    check("R1 reset valid", {19'd0, ov}, 20'd0);
    check("R1 reset code 1-lane", {10'd0, code1}, {10'd0, 10'h0FA});
    @(posedge clk); #1;
    rst = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic t_idle_i2;
    send2(8'h00, 8'hBC, 2'b01, 2'b00, 2'b00, 1'b0, 1'b0);  // R5 R6 from negative
    check("R6 comma then D16.2", code, {10'h245, 10'h0FA});
    check("R10 valid after accept", {19'd0, ov}, 20'd1);
    send2(8'h00, 8'h00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0);  // R2 R3
    check("R2 D0.0 pair from negative", code, {10'h274, 10'h274});
  endtask

  task automatic t_kcodes;
    send2(8'hF7, 8'h00, 2'b11, 2'b00, 2'b00, 1'b0, 1'b0);  // R4
    check("R4 K23.7 and invalid K0.0", code, {10'h3A8, 10'h274});
  endtask

  task automatic t_idle_i1;
    send2(8'hBC, 8'h00, 2'b10, 2'b00, 2'b00, 1'b0, 1'b0);  // R3 comma in high lane, no pair
    check("R3 comma in upper lane", code, {10'h0FA, 10'h274});
    send2(8'h00, 8'hBC, 2'b01, 2'b00, 2'b00, 1'b0, 1'b0);  // R6 from positive
    check("R6 comma then D5.6", code, {10'h296, 10'h305});
  endtask

  task automatic t_exclusions;
    send2(8'hB5, 8'hBC, 2'b01, 2'b00, 2'b00, 1'b0, 1'b0);  // R5
    check("R5 D21.5 kept", code, {10'h2AA, 10'h0FA});
    send2(8'h42, 8'hBC, 2'b01, 2'b00, 2'b00, 1'b0, 1'b0);  // R5
    check("R5 D2.2 kept", code, {10'h2D5, 10'h305});
  endtask

  task automatic t_force_bypass;
    send2(8'h00, 8'h00, 2'b00, 2'b11, 2'b10, 1'b0, 1'b0);  // R7 tracked positive
    check("R7 both lanes forced", code, {10'h18B, 10'h274});
    send2(8'h00, 8'hBC, 2'b01, 2'b00, 2'b00, 1'b1, 1'b0);  // R8
    check("R8 bypass raw bytes", code, {10'h000, 10'h0BC});
    send2(8'h00, 8'h00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0);  // R8 disparity still positive
    check("R8 disparity kept over bypass", code, {10'h18B, 10'h18B});
    send2(8'h00, 8'h00, 2'b00, 2'b01, 2'b00, 1'b0, 1'b0);  // R7 chaining
    check("R7 lane 0 forced, lane 1 follows", code, {10'h274, 10'h274});
  endtask

  task automatic t_reverse;
    send2(8'h00, 8'h01, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1);  // R9 bypass
    check("R9 mirror in bypass", code, 20'h80000);
    send2(8'h00, 8'h00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1);  // R9 encoded
    check("R9 mirror encoded", code, mirror20({10'h274, 10'h274}));
  endtask

  task automatic t_stall;
    logic [19:0] held;
    held = code;
    ordy = 1'b0;
    din = 16'h0000; kk = 2'b00; frc = 2'b00; byp = 1'b0; rev = 1'b0; iv = 1'b1;
    for (int n = 0; n < 2; n++) begin
      @(posedge clk); #1;
      check("R10 held while stalled", code, held);
      check("R10 not ready while stalled", {19'd0, irdy}, 20'd0);
    end
    ordy = 1'b1;
    @(posedge clk); #1;
    iv = 1'b0;
    check("R10 taken after stall", code, {10'h274, 10'h274});
    @(posedge clk); #1;
    check("R10 valid drops when empty", {19'd0, ov}, 20'd0);
  endtask

  task automatic t_one_lane;
    send1(8'hBC, 1'b1);
    check("R5 1-lane comma", {10'd0, code1}, {10'd0, 10'h0FA});
    send1(8'h00, 1'b0);
    check("R6 1-lane rewrite across beats", {10'd0, code1}, {10'd0, 10'h245});
    send1(8'hBC, 1'b1);
    send1(8'hB5, 1'b0);
    check("R5 1-lane D21.5 kept", {10'd0, code1}, {10'd0, 10'h2AA});
  endtask

  task automatic t_random;
    logic rd_m;
    logic [7:0] lo, hi;
    logic [1:0] k;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    rd_m = 1'b0;
    for (int n = 0; n < 300; n++) begin
      hi = 8'($urandom);
      lo = 8'($urandom);
      k  = 2'b00;
      if (($urandom % 3) == 0) begin lo = 8'hBC; k[0] = 1'b1; end
      if (($urandom % 8) == 0) begin hi = 8'h3C; k[1] = 1'b1; end
      if (($urandom % 6) == 0) hi = (n % 2 == 0) ? 8'hB5 : 8'h42;
      send2(hi, lo, k, 2'b00, 2'b00, 1'b0, 1'b0);
      for (int l = 0; l < 2; l++) begin
        int ones;
        ones = $countones(code[l*10 +: 10]);
        if (rd_m) check("R2 group weight at positive", {19'd0, (ones == 4 || ones == 5)}, 20'd1);
        else      check("R2 group weight at negative", {19'd0, (ones == 5 || ones == 6)}, 20'd1);
        if (ones == 6) rd_m = 1'b1;
        else if (ones == 4) rd_m = 1'b0;
      end
      if (k == 2'b01 && hi != 8'hB5 && hi != 8'h42)
        check("R6 negative after idle set", {19'd0, rd_m}, 20'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    byp = 1'b0; rev = 1'b0; iv = 1'b0; ordy = 1'b1;
    din = 16'h0000; kk = 2'b00; frc = 2'b00; dv = 2'b00;
    iv1 = 1'b0; din1 = 8'h00; k1 = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    t_reset();
    t_idle_i2();
    t_kcodes();
    t_idle_i1();
    t_exclusions();
    t_force_bypass();
    t_reverse();
    t_stall();
    t_one_lane();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule